// File: doc/BRIEF.md
# Slave Serial Configuration Sequencer

This block loads a configuration image into a target device through the device's serial configuration pins. A single start strobe latches the image length, turns on the target's supply enable and waits for the supply to settle. It then pulls the active-low program pin for a hold time and releases it. Next it polls the target's init pin until the target is ready. Each image byte is then taken from a valid/ready byte stream and shifted out on a data pin, most significant bit first, with a configuration clock pin.

After the last byte the block keeps issuing clock pulses until the target raises its done pin. Both waits on the target are bounded. A byte flagged as bad by the stream ends the run. Every run ends with exactly one single-cycle status pulse: success, timeout or stream abort. The busy output covers the whole run, so a system controller only needs to strobe start, feed bytes and watch for the pulse.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset the pins sit at their idle levels: cfgProgN=1, cfgClk=0, cfgData=0, pwrEn=0, busy=0, byteRdy=0. Whenever busy is 0, cfgProgN=1, cfgClk=0 and cfgData=0.
- R2: On start, pwrEn goes to 1 and stays 1 until reset. cfgProgN stays high for at least SETTLE_CYC cycles after pwrEn rises, is then driven low for at least HOLD_CYC cycles, and is then released high. cfgClk stays 0 while cfgProgN is low.
- R3: After the program release, init is polled once per divided-clock tick. If init has not been seen high by the INIT_POLLS-th poll, timeoutErr pulses and busy falls. In that case no clock pulse is issued and no byte is taken.
- R4: Each byte is sent most significant bit first. cfgData changes only while cfgClk is 0, so the target captures bit i on the i-th rising edge of cfgClk.
- R5: Every high phase of cfgClk lasts exactly CLK_DIV cycles. Every low phase between two pulses lasts at least CLK_DIV cycles.
- R6: Exactly imgLen bytes are taken, each one on a cycle where byteVld and byteRdy are both 1. byteRdy is 1 only while busy and while cfgClk is 0. With imgLen=0 no byte is taken and the block goes straight to the done phase.
- R7: A byte offered with byteErr=1 while byteRdy=1 ends the run: streamAbort pulses, busy falls, and no further clock pulse is issued.
- R8: After the data, extra clock pulses are issued until done is seen high at the end of a low phase. cfgOk then pulses. If done is already high when the last data bit is clocked, no extra pulse is issued.
- R9: If done is still low after DONE_PULSES extra pulses, timeoutErr pulses and busy falls.
- R10: busy is 1 from the cycle after start until the cycle of the ending pulse, and it is 0 in that cycle. A start while busy is ignored: neither the latched length nor the sequence changes.
- R11: cfgOk, timeoutErr and streamAbort are single-cycle pulses. At most one of them is 1 in any cycle, and each run ends with exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a configuration run when idle |
| imgLen | input | LEN_W | Image length in bytes, latched on start |
| byteVld | input | 1 | Stream byte is present |
| byteData | input | 8 | Stream byte |
| byteErr | input | 1 | Stream byte is bad; aborts the run |
| byteRdy | output | 1 | Block takes a byte this cycle if byteVld |
| initIn | input | 1 | Target ready-for-data pin |
| doneIn | input | 1 | Target configuration complete pin |
| cfgProgN | output | 1 | Target program pin, active low |
| cfgClk | output | 1 | Configuration clock pin |
| cfgData | output | 1 | Configuration data pin |
| pwrEn | output | 1 | Target supply enable |
| busy | output | 1 | Run in progress |
| cfgOk | output | 1 | Success pulse |
| timeoutErr | output | 1 | Init or done timeout pulse |
| streamAbort | output | 1 | Stream error pulse |

## Verification
The hardest case to reach is the edge of the done phase. Done may arrive exactly as the final data bit is clocked, which must produce zero extra pulses, or it may never arrive, which must produce exactly the limit number of pulses. The bench's target model raises done at a chosen rising-edge count of cfgClk, so that count can be placed on the last data bit, a few pulses past the data, or never. The stream source marks a chosen byte as bad, so the abort can be made to land between two bytes of a run.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [1:0] {
    SPAN_SETTLE,
    SPAN_HOLD,
    SPAN_INIT,
    SPAN_DONE
  } span_sel_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POWER,
    ST_PROG,
    ST_INITW,
    ST_LOAD,
    ST_BLOW,
    ST_BHIGH,
    ST_DLOW,
    ST_DHIGH
  } seq_state_e;

  // strobes and pin levels from control to datapath
  typedef struct packed {
    logic      spanClr;
    logic      spanInc;
    span_sel_e spanSel;
    logic      divClr;
    logic      lenLoad;
    logic      byteTake;
    logic      bitShift;
    logic      pwrSet;
    logic      pinProgLow;
    logic      pinClkHigh;
    logic      pinDataEn;
  } dp_ctrl_t;

  // conditions reported by the datapath
  typedef struct packed {
    logic tick;
    logic spanFull;
    logic lastBit;
    logic lastByte;
    logic lenZero;
  } dp_stat_t;

endpackage

// File: rtl/cfg_seq_dp.sv
module cfg_seq_dp
  import cfg_loader_pkg::*;
#(
  parameter int CLK_DIV     = 6,
  parameter int SETTLE_CYC  = 1200000,
  parameter int HOLD_CYC    = 1200000,
  parameter int INIT_POLLS  = 100000,
  parameter int DONE_PULSES = 100000,
  parameter int LEN_W       = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_ctrl_t         ctl,
  input  logic [LEN_W-1:0] imgLen,
  input  logic [7:0]       byteData,
  output dp_stat_t         stat,
  output logic             cfgProgN,
  output logic             cfgClk,
  output logic             cfgData,
  output logic             pwrEn
);

  localparam int MAX_A  = (SETTLE_CYC > HOLD_CYC) ? SETTLE_CYC : HOLD_CYC;
  localparam int MAX_B  = (INIT_POLLS > DONE_PULSES) ? INIT_POLLS : DONE_PULSES;
  localparam int SPAN_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int SPAN_W = $clog2(SPAN_MAX + 1);
  localparam int DIV_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DIV_W-1:0]  divCnt;
  logic [SPAN_W-1:0] spanCnt;
  logic [SPAN_W-1:0] spanLim;
  logic [LEN_W-1:0]  lenReg;
  logic [LEN_W-1:0]  byteCnt;
  logic [7:0]        shiftReg;
  logic [2:0]        bitCnt;
  logic              pwrReg;
  logic              tick;

  assign tick = (divCnt == DIV_W'(CLK_DIV - 1));

  // phase divider: restarts on request and at every tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                divCnt <= '0;
    else if (ctl.divClr || tick) divCnt <= '0;
    else                      divCnt <= divCnt + 1'b1;
  end

  // shared span counter for settle, hold, init polls and done pulses
  always_comb begin
    unique case (ctl.spanSel)
      SPAN_SETTLE: spanLim = SPAN_W'(SETTLE_CYC);
      SPAN_HOLD:   spanLim = SPAN_W'(HOLD_CYC);
      SPAN_INIT:   spanLim = SPAN_W'(INIT_POLLS - 1);
      default:     spanLim = SPAN_W'(DONE_PULSES);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            spanCnt <= '0;
    else if (ctl.spanClr) spanCnt <= '0;
    else if (ctl.spanInc) spanCnt <= spanCnt + 1'b1;
  end

  // length and byte accounting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenReg  <= '0;
      byteCnt <= '0;
    end else if (ctl.lenLoad) begin
      lenReg  <= imgLen;
      byteCnt <= '0;
    end else if (ctl.byteTake) begin
      byteCnt <= byteCnt + 1'b1;
    end
  end

  // byte shifter, MSB leaves first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (ctl.byteTake) begin
      shiftReg <= byteData;
      bitCnt   <= '0;
    end else if (ctl.bitShift) begin
      shiftReg <= {shiftReg[6:0], 1'b0};
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           pwrReg <= 1'b0;
    else if (ctl.pwrSet) pwrReg <= 1'b1;
  end

  assign stat.tick     = tick;
  assign stat.spanFull = (spanCnt == spanLim);
  assign stat.lastBit  = (bitCnt == 3'd7);
  assign stat.lastByte = (byteCnt == lenReg);
  assign stat.lenZero  = (lenReg == '0);

  assign cfgProgN = ~ctl.pinProgLow;
  assign cfgClk   = ctl.pinClkHigh;
  assign cfgData  = ctl.pinDataEn & shiftReg[7];
  assign pwrEn    = pwrReg;

endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_loader_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     byteVld,
  input  logic     byteErr,
  input  logic     initIn,
  input  logic     doneIn,
  input  dp_stat_t stat,
  output dp_ctrl_t ctl,
  output logic     busy,
  output logic     byteRdy,
  output logic     cfgOk,
  output logic     timeoutErr,
  output logic     streamAbort
);

  seq_state_e state, nxt;
  logic endOk, endTo, endAb;

  always_comb begin
    nxt   = state;
    ctl   = '0;
    ctl.spanSel = SPAN_SETTLE;
    endOk = 1'b0;
    endTo = 1'b0;
    endAb = 1'b0;
    ctl.pinProgLow = (state == ST_PROG);
    ctl.pinClkHigh = (state == ST_BHIGH) || (state == ST_DHIGH);
    ctl.pinDataEn  = (state == ST_BLOW) || (state == ST_BHIGH);
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.lenLoad = 1'b1;
          ctl.pwrSet  = 1'b1;
          ctl.spanClr = 1'b1;
          nxt = ST_POWER;
        end
      end
      ST_POWER: begin
        ctl.spanSel = SPAN_SETTLE;
        if (stat.spanFull) begin
          ctl.spanClr = 1'b1;
          nxt = ST_PROG;
        end else begin
          ctl.spanInc = 1'b1;
        end
      end
      ST_PROG: begin
        ctl.spanSel = SPAN_HOLD;
        if (stat.spanFull) begin
          ctl.spanClr = 1'b1;
          ctl.divClr  = 1'b1;
          nxt = ST_INITW;
        end else begin
          ctl.spanInc = 1'b1;
        end
      end
      ST_INITW: begin
        ctl.spanSel = SPAN_INIT;
        if (stat.tick) begin
          if (initIn) begin
            ctl.spanClr = 1'b1;
            ctl.divClr  = 1'b1;
            nxt = stat.lenZero ? ST_DLOW : ST_LOAD;
          end else if (stat.spanFull) begin
            endTo = 1'b1;
            nxt = ST_IDLE;
          end else begin
            ctl.spanInc = 1'b1;
          end
        end
      end
      ST_LOAD: begin
        if (byteVld) begin
          if (byteErr) begin
            endAb = 1'b1;
            nxt = ST_IDLE;
          end else begin
            ctl.byteTake = 1'b1;
            ctl.divClr   = 1'b1;
            nxt = ST_BLOW;
          end
        end
      end
      ST_BLOW: begin
        if (stat.tick) nxt = ST_BHIGH;
      end
      ST_BHIGH: begin
        if (stat.tick) begin
          if (!stat.lastBit) begin
            ctl.bitShift = 1'b1;
            nxt = ST_BLOW;
          end else if (stat.lastByte) begin
            ctl.spanClr = 1'b1;
            nxt = ST_DLOW;
          end else begin
            nxt = ST_LOAD;
          end
        end
      end
      ST_DLOW: begin
        ctl.spanSel = SPAN_DONE;
        if (stat.tick) begin
          if (doneIn) begin
            endOk = 1'b1;
            nxt = ST_IDLE;
          end else if (stat.spanFull) begin
            endTo = 1'b1;
            nxt = ST_IDLE;
          end else begin
            nxt = ST_DHIGH;
          end
        end
      end
      ST_DHIGH: begin
        ctl.spanSel = SPAN_DONE;
        if (stat.tick) begin
          ctl.spanInc = 1'b1;
          nxt = ST_DLOW;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      cfgOk       <= 1'b0;
      timeoutErr  <= 1'b0;
      streamAbort <= 1'b0;
    end else begin
      state       <= nxt;
      cfgOk       <= endOk;
      timeoutErr  <= endTo;
      streamAbort <= endAb;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign byteRdy = (state == ST_LOAD);

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int CLK_DIV     = 6,
  parameter int SETTLE_CYC  = 1200000,
  parameter int HOLD_CYC    = 1200000,
  parameter int INIT_POLLS  = 100000,
  parameter int DONE_PULSES = 100000,
  parameter int LEN_W       = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] imgLen,
  input  logic             byteVld,
  input  logic [7:0]       byteData,
  input  logic             byteErr,
  output logic             byteRdy,
  input  logic             initIn,
  input  logic             doneIn,
  output logic             cfgProgN,
  output logic             cfgClk,
  output logic             cfgData,
  output logic             pwrEn,
  output logic             busy,
  output logic             cfgOk,
  output logic             timeoutErr,
  output logic             streamAbort
);

  dp_ctrl_t ctl;
  dp_stat_t stat;

  cfg_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .byteVld    (byteVld),
    .byteErr    (byteErr),
    .initIn     (initIn),
    .doneIn     (doneIn),
    .stat       (stat),
    .ctl        (ctl),
    .busy       (busy),
    .byteRdy    (byteRdy),
    .cfgOk      (cfgOk),
    .timeoutErr (timeoutErr),
    .streamAbort(streamAbort)
  );

  cfg_seq_dp #(
    .CLK_DIV    (CLK_DIV),
    .SETTLE_CYC (SETTLE_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .INIT_POLLS (INIT_POLLS),
    .DONE_PULSES(DONE_PULSES),
    .LEN_W      (LEN_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .imgLen  (imgLen),
    .byteData(byteData),
    .stat    (stat),
    .cfgProgN(cfgProgN),
    .cfgClk  (cfgClk),
    .cfgData (cfgData),
    .pwrEn   (pwrEn)
  );

endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk #(
  parameter int CLK_DIV = 6
) (
  input logic clk,
  input logic rstN,
  input logic byteRdy,
  input logic cfgProgN,
  input logic cfgClk,
  input logic cfgData,
  input logic busy,
  input logic cfgOk,
  input logic timeoutErr,
  input logic streamAbort
);

  logic [15:0] hiRun;
  logic        anyEnd;

  assign anyEnd = cfgOk | timeoutErr | streamAbort;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       hiRun <= '0;
    else if (cfgClk) hiRun <= hiRun + 1'b1;
    else             hiRun <= '0;
  end

  // R1: idle pin levels
  a_r1_idle_levels: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (cfgProgN && !cfgClk && !cfgData));

  // R2: no clock while program is held low
  a_r2_no_clk_in_prog: assert property (@(posedge clk) disable iff (!rstN)
    !cfgProgN |-> !cfgClk);

  // R4: data held steady across the high phase
  a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    (cfgClk && $past(cfgClk)) |-> $stable(cfgData));

  // R5: each high phase lasts exactly the divided period
  a_r5_high_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cfgClk) |-> (hiRun == 16'(CLK_DIV)));

  // R6: ready only during a run with the clock low
  a_r6_rdy_window: assert property (@(posedge clk) disable iff (!rstN)
    byteRdy |-> (busy && !cfgClk));

  // R10: ending pulse coincides with busy low
  a_r10_end_clears_busy: assert property (@(posedge clk) disable iff (!rstN)
    anyEnd |-> !busy);

  // R10: busy holds until an ending pulse
  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && !busy) |-> anyEnd);

  // R11: at most one ending pulse, each one cycle
  a_r11_one_end: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cfgOk, timeoutErr, streamAbort}));

  a_r11_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    anyEnd |=> !anyEnd);

endmodule

bind cfg_serial_loader cfg_seq_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .byteRdy    (byteRdy),
  .cfgProgN   (cfgProgN),
  .cfgClk     (cfgClk),
  .cfgData    (cfgData),
  .busy       (busy),
  .cfgOk      (cfgOk),
  .timeoutErr (timeoutErr),
  .streamAbort(streamAbort)
);

// File: tb/sim_cfg_serial_loader.sv
`timescale 1ns/1ps
module sim_cfg_serial_loader;

  localparam int CLK_DIV     = 2;
  localparam int SETTLE_CYC  = 20;
  localparam int HOLD_CYC    = 10;
  localparam int INIT_POLLS  = 16;
  localparam int DONE_PULSES = 12;
  localparam int LEN_W       = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] imgLen = '0;
  logic byteVld = 1'b0;
  logic [7:0] byteData = '0;
  logic byteErr = 1'b0;
  logic byteRdy;
  logic initIn = 1'b0;
  logic doneIn = 1'b0;
  logic cfgProgN, cfgClk, cfgData, pwrEn, busy, cfgOk, timeoutErr, streamAbort;

  always #5 clk = ~clk;

  cfg_serial_loader #(
    .CLK_DIV(CLK_DIV), .SETTLE_CYC(SETTLE_CYC), .HOLD_CYC(HOLD_CYC),
    .INIT_POLLS(INIT_POLLS), .DONE_PULSES(DONE_PULSES), .LEN_W(LEN_W)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .imgLen(imgLen),
    .byteVld(byteVld), .byteData(byteData), .byteErr(byteErr), .byteRdy(byteRdy),
    .initIn(initIn), .doneIn(doneIn), .cfgProgN(cfgProgN), .cfgClk(cfgClk),
    .cfgData(cfgData), .pwrEn(pwrEn), .busy(busy), .cfgOk(cfgOk),
    .timeoutErr(timeoutErr), .streamAbort(streamAbort)
  );

  int total = 0;
  int bad = 0;

  // scenario configuration
  logic [7:0] srcMem [8];
  int srcLen = 0;
  int errIdx = -1;
  int doneAt = 0;
  int expLen = 0;

  // stream source state
  int srcIdx = 0;
  int goodTaken = 0;
  bit prevTake = 0;

  // monitor state
  int cyc = 0;
  int edges = 0;
  logic [7:0] rxShift = '0;
  logic [7:0] rxMem [8];
  int runLen = 0;
  int hiMin = 0, hiMax = 0, loMin = 0;
  int dataBad = 0;
  int okCnt = 0, toCnt = 0, abCnt = 0;
  int pwrRiseCyc = 0, progFallCyc = 0, progLowLen = 0;
  logic prevClk = 0, prevData = 0, prevProg = 1, prevPwr = 0;

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // byte stream source, driven away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      srcIdx = 0; goodTaken = 0; prevTake = 0;
      byteVld = 0; byteErr = 0; byteData = '0;
    end else begin
      if (prevTake) begin
        if (srcIdx != errIdx) goodTaken++;
        srcIdx++;
      end
      byteVld  = (srcIdx < srcLen);
      byteData = (srcIdx < 8) ? srcMem[srcIdx] : 8'h00;
      byteErr  = (srcIdx == errIdx);
      prevTake = byteVld && byteRdy;
    end
  end

  // target model and pin monitor
  always @(negedge clk) begin
    if (!rstN) begin
      cyc = 0; edges = 0; rxShift = '0; runLen = 0;
      hiMin = 1000000; hiMax = 0; loMin = 1000000; dataBad = 0;
      okCnt = 0; toCnt = 0; abCnt = 0;
      pwrRiseCyc = 0; progFallCyc = 0; progLowLen = 0;
      prevClk = 0; prevData = 0; prevProg = 1; prevPwr = 0;
      doneIn = 0;
    end else begin
      cyc++;
      if (cfgClk && !prevClk) begin
        edges++;
        rxShift = {rxShift[6:0], cfgData};
        if (edges <= 8 * expLen && (edges % 8) == 0) rxMem[edges/8 - 1] = rxShift;
        if (doneAt != 0 && edges == doneAt) doneIn = 1;
      end
      if (cfgClk == prevClk) runLen++;
      else begin
        if (prevClk) begin
          if (runLen < hiMin) hiMin = runLen;
          if (runLen > hiMax) hiMax = runLen;
        end else if (edges > 1) begin
          if (runLen < loMin) loMin = runLen;
        end
        runLen = 1;
      end
      if (cfgClk && prevClk && cfgData != prevData) dataBad++;
      if (pwrEn && !prevPwr) pwrRiseCyc = cyc;
      if (!cfgProgN && prevProg) progFallCyc = cyc;
      if (cfgProgN && !prevProg) progLowLen = cyc - progFallCyc;
      okCnt += int'(cfgOk);
      toCnt += int'(timeoutErr);
      abCnt += int'(streamAbort);
      prevClk = cfgClk; prevData = cfgData; prevProg = cfgProgN; prevPwr = pwrEn;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rstN = 0; initIn = 0; start = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  // runs one configuration; returns cycles from program release to busy low
  task automatic do_run(input int len, input int initDly, input bit midStart, output int waitCyc);
    int n;
    imgLen = LEN_W'(len);
    start = 1;
    @(negedge clk);
    start = 0;
    n = 0;
    while (cfgProgN && n < 5000) begin @(negedge clk); n++; end
    n = 0;
    while (!cfgProgN && n < 5000) begin @(negedge clk); n++; end
    waitCyc = 0;
    if (initDly >= 0) begin
      repeat (initDly) begin @(negedge clk); waitCyc++; end
      initIn = 1;
    end
    if (midStart) begin
      repeat (10) begin @(negedge clk); waitCyc++; end
      imgLen = LEN_W'(len + 2);
      start = 1;
      @(negedge clk); waitCyc++;
      start = 0;
    end
    n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; waitCyc++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(cfgProgN == 1, "R1 progN idle", int'(cfgProgN), 1);
    chk(cfgClk == 0 && cfgData == 0, "R1 clk/data idle", int'({cfgClk, cfgData}), 0);
    chk(pwrEn == 0, "R1 pwrEn idle", int'(pwrEn), 0);
    chk(busy == 0 && byteRdy == 0, "R1 busy/rdy idle", int'({busy, byteRdy}), 0);
  endtask

  task automatic t_normal();
    int w;
    srcMem[0] = 8'hA5; srcMem[1] = 8'h3C; srcMem[2] = 8'h81;
    srcLen = 3; errIdx = -1; expLen = 3; doneAt = 29;
    do_reset();
    do_run(3, 3, 1, w);
    chk(rxMem[0] == 8'hA5, "R4 byte0 msb first", int'(rxMem[0]), 'hA5);
    chk(rxMem[1] == 8'h3C, "R4 byte1 msb first", int'(rxMem[1]), 'h3C);
    chk(rxMem[2] == 8'h81, "R4 byte2 msb first", int'(rxMem[2]), 'h81);
    chk(dataBad == 0, "R4 data steady while high", dataBad, 0);
    chk(progFallCyc - pwrRiseCyc >= SETTLE_CYC, "R2 settle before program", progFallCyc - pwrRiseCyc, SETTLE_CYC);
    chk(progLowLen >= HOLD_CYC, "R2 program low time", progLowLen, HOLD_CYC);
    chk(pwrEn == 1, "R2 pwrEn stays on", int'(pwrEn), 1);
    chk(hiMin == CLK_DIV && hiMax == CLK_DIV, "R5 high phase width", hiMin, CLK_DIV);
    chk(loMin >= CLK_DIV, "R5 low phase width", loMin, CLK_DIV);
    chk(goodTaken == 3, "R6 R10 bytes taken, restart ignored", goodTaken, 3);
    chk(edges == 29, "R8 extra pulses until done", edges, 29);
    chk(okCnt == 1 && toCnt == 0 && abCnt == 0, "R11 single success", okCnt, 1);
    chk(busy == 0, "R10 busy low after end", int'(busy), 0);
  endtask

  task automatic t_init_timeout();
    int w;
    srcMem[0] = 8'h55; srcLen = 1; errIdx = -1; expLen = 1; doneAt = 1;
    do_reset();
    do_run(1, -1, 0, w);
    chk(toCnt == 1 && okCnt == 0, "R3 init timeout pulse", toCnt, 1);
    chk(edges == 0, "R3 no clock on init timeout", edges, 0);
    chk(goodTaken == 0, "R3 no byte taken", goodTaken, 0);
    chk(w >= INIT_POLLS * CLK_DIV && w <= INIT_POLLS * CLK_DIV + 4, "R3 poll bound", w, INIT_POLLS * CLK_DIV);
  endtask

  task automatic t_done_timeout();
    int w;
    srcMem[0] = 8'hC3; srcLen = 1; errIdx = -1; expLen = 1; doneAt = 0;
    do_reset();
    do_run(1, 2, 0, w);
    chk(rxMem[0] == 8'hC3, "R4 single byte", int'(rxMem[0]), 'hC3);
    chk(edges == 8 + DONE_PULSES, "R9 pulses before done timeout", edges, 8 + DONE_PULSES);
    chk(toCnt == 1 && okCnt == 0, "R9 done timeout pulse", toCnt, 1);
  endtask

  task automatic t_stream_abort();
    int w;
    srcMem[0] = 8'h0F; srcMem[1] = 8'hF0; srcMem[2] = 8'h11;
    srcLen = 3; errIdx = 1; expLen = 3; doneAt = 0;
    do_reset();
    do_run(3, 1, 0, w);
    chk(abCnt == 1 && okCnt == 0 && toCnt == 0, "R7 abort pulse", abCnt, 1);
    chk(goodTaken == 1, "R7 bytes before abort", goodTaken, 1);
    chk(edges == 8, "R7 no clock after abort", edges, 8);
    chk(rxMem[0] == 8'h0F, "R7 first byte intact", int'(rxMem[0]), 'h0F);
  endtask

  task automatic t_zero_len();
    int w;
    srcMem[0] = 8'h77; srcLen = 1; errIdx = -1; expLen = 0; doneAt = 2;
    do_reset();
    do_run(0, 2, 0, w);
    chk(goodTaken == 0, "R6 zero length takes nothing", goodTaken, 0);
    chk(edges == 2, "R6 zero length done pulses", edges, 2);
    chk(okCnt == 1, "R8 zero length success", okCnt, 1);
  endtask

  task automatic t_done_early();
    int w;
    srcMem[0] = 8'h96; srcMem[1] = 8'h4B;
    srcLen = 2; errIdx = -1; expLen = 2; doneAt = 16;
    do_reset();
    do_run(2, 4, 0, w);
    chk(edges == 16, "R8 no extra pulse when done early", edges, 16);
    chk(rxMem[1] == 8'h4B, "R4 second byte", int'(rxMem[1]), 'h4B);
    chk(okCnt == 1 && toCnt == 0, "R11 success only", okCnt, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_normal();
    t_init_timeout();
    t_done_timeout();
    t_stream_abort();
    t_zero_len();
    t_done_early();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule